// File: doc/BRIEF.md
# Conversion Result Display Latch with Range Flags

This block sits between a free-running measurement core and a display driver. The core counts up to three and three-quarter digits and produces a new result at the end of every conversion, either an analog-to-digital count or a frequency count. When the core reports a finished conversion, the block captures the count and drives an active-low end-of-conversion strobe for a fixed number of clocks. At the close of that strobe it copies the count into the display register, unless a hold request is present.

The hold request is asynchronous and is synchronized before use. It freezes the displayed reading while the core keeps converting, and the strobe keeps running under hold. Two range flags, over full scale and at or below the low limit, are registered with the displayed value. A range pulse is produced for each conversion whose count falls outside the range, so that external auto-ranging logic sees one pulse per such conversion even while the display is frozen.

Top module: `range_display_latch`

## Requirements
- R1: A conversion-done pulse sampled while no strobe is running makes `eocN` go low on the next clock, and it stays low for exactly STROBE_LEN (default 10) consecutive cycles.
- R2: When hold is not active, `dispCount` takes the count present with the accepted conversion-done pulse on the same clock on which `eocN` returns high.
- R3: If the synchronized hold is high when the strobe ends, `dispCount`, `overRange` and `underRange` keep their previous values. Hold passes through SYNC_STAGES (default 2) flops.
- R4: While hold is active, conversions are still accepted, and `eocN` and `rangePulse` behave exactly as they do without hold.
- R5: `overRange` is 1 exactly when the displayed count is greater than FULL_SCALE (default 3999).
- R6: `underRange` is 1 exactly when the displayed count is less than or equal to LOW_LIMIT (default 380). Both flags stay 0 after reset until the first load.
- R7: `rangePulse` is 1 in every cycle in which `eocN` is low for a conversion whose captured count is above FULL_SCALE or at most LOW_LIMIT. It is 0 in every other cycle.
- R8: A conversion-done pulse that arrives while `eocN` is low is ignored. The strobe length is unchanged, and the display receives the count that started the strobe.
- R9: A synchronous active-high reset sets `eocN` to 1 and sets `dispCount`, `overRange`, `underRange` and `rangePulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| convDone | input | 1 | One-cycle pulse from the core when a conversion finishes |
| convCount | input | CNT_W | Result count, valid together with convDone |
| holdReq | input | 1 | Asynchronous display-freeze request, active high |
| eocN | output | 1 | Active-low end-of-conversion strobe |
| dispCount | output | CNT_W | Count shown on the display |
| overRange | output | 1 | Displayed count above full scale |
| underRange | output | 1 | Displayed count at or below the low limit |
| rangePulse | output | 1 | High during the strobe of an out-of-range conversion |

## Verification
The bench builds the block with the default parameters: a 12-bit count, a 10-cycle strobe and a 2-flop synchronizer. With a 12-bit count, every input value from 0 to 4095 can be driven through a full conversion. This covers both flag boundaries (380/381 and 3999/4000) and the region above full scale. Hold is applied on a fixed subset of those values, and overlapping conversion-done pulses are injected in the middle of strobes. This shows that frozen displays, continued strobes and ignored pulses all behave correctly across the whole range.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  typedef struct packed {
    logic capture;  // accept a new count and start the strobe
    logic load;     // copy the captured count to the display
  } ctrlStrobes_t;
endpackage

// File: rtl/rdl_ctrl.sv
module rdl_ctrl
  import rdl_pkg::*;
#(
  parameter int STROBE_LEN  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         convDone,
  input  logic         holdReq,
  output ctrlStrobes_t strb,
  output logic         strobeActive,
  output logic         holdSync
);
  localparam int CW = $clog2(STROBE_LEN + 1);

  logic [SYNC_STAGES-1:0] holdPipe;
  logic [CW-1:0]          cnt;
  logic                   lastCycle;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) holdPipe <= '0;
        else     holdPipe <= holdReq;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) holdPipe <= '0;
        else     holdPipe <= {holdPipe[SYNC_STAGES-2:0], holdReq};
      end
    end
  endgenerate

  assign holdSync  = holdPipe[SYNC_STAGES-1];
  assign lastCycle = strobeActive && (cnt == CW'(STROBE_LEN - 1));

  always_comb begin
    strb.capture = convDone && !strobeActive;
    strb.load    = lastCycle && !holdSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobeActive <= 1'b0;
      cnt          <= '0;
    end else if (strb.capture) begin
      strobeActive <= 1'b1;
      cnt          <= '0;
    end else if (lastCycle) begin
      strobeActive <= 1'b0;
      cnt          <= '0;
    end else if (strobeActive) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Independent run-length counter that checks the strobe width
  logic [CW:0] lowRun;
  always_ff @(posedge clk) begin
    if (rst)               lowRun <= '0;
    else if (strobeActive) lowRun <= lowRun + 1'b1;
    else                   lowRun <= '0;
  end

  // R1
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobeActive) |-> lowRun == (CW+1)'(STROBE_LEN));

  // R8
  busy_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (strobeActive && !lastCycle) |=> strobeActive);
endmodule

// File: rtl/rdl_datapath.sv
module rdl_datapath
  import rdl_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int FULL_SCALE = 3999,
  parameter int LOW_LIMIT  = 380
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic [CNT_W-1:0] convCount,
  output logic [CNT_W-1:0] dispCount,
  output logic             overRange,
  output logic             underRange,
  output logic             pendOut
);
  localparam logic [CNT_W-1:0] FS = CNT_W'(FULL_SCALE);
  localparam logic [CNT_W-1:0] LL = CNT_W'(LOW_LIMIT);

  logic [CNT_W-1:0] captured;

  always_ff @(posedge clk) begin
    if (rst) begin
      captured <= '0;
      pendOut  <= 1'b0;
    end else if (strb.capture) begin
      captured <= convCount;
      pendOut  <= (convCount > FS) || (convCount <= LL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dispCount  <= '0;
      overRange  <= 1'b0;
      underRange <= 1'b0;
    end else if (strb.load) begin
      dispCount  <= captured;
      overRange  <= captured > FS;
      underRange <= captured <= LL;
    end
  end

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(overRange && underRange));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> dispCount == $past(captured));
endmodule

// File: rtl/range_display_latch.sv
module range_display_latch
  import rdl_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int STROBE_LEN  = 10,
  parameter int SYNC_STAGES = 2,
  parameter int FULL_SCALE  = 3999,
  parameter int LOW_LIMIT   = 380
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             convDone,
  input  logic [CNT_W-1:0] convCount,
  input  logic             holdReq,
  output logic             eocN,
  output logic [CNT_W-1:0] dispCount,
  output logic             overRange,
  output logic             underRange,
  output logic             rangePulse
);
  ctrlStrobes_t strb;
  logic         strobeActive;
  logic         holdSync;
  logic         pendOut;

  rdl_ctrl #(.STROBE_LEN(STROBE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .convDone(convDone), .holdReq(holdReq),
    .strb(strb), .strobeActive(strobeActive), .holdSync(holdSync)
  );

  rdl_datapath #(.CNT_W(CNT_W), .FULL_SCALE(FULL_SCALE), .LOW_LIMIT(LOW_LIMIT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .convCount(convCount),
    .dispCount(dispCount), .overRange(overRange), .underRange(underRange),
    .pendOut(pendOut)
  );

  assign eocN       = ~strobeActive;
  assign rangePulse = strobeActive & pendOut;

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    holdSync |=> ($stable(dispCount) && $stable(overRange) && $stable(underRange)));

  // R7
  pulse_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rangePulse |-> !eocN);

  // R8
  busy_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!eocN && convDone) |=> $stable(pendOut));
endmodule

// File: tb/tb_range_display_latch.sv
module tb_range_display_latch;
  localparam int CNT_W = 12;
  localparam int SLEN  = 10;
  localparam int FS    = 3999;
  localparam int LL    = 380;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             convDone = 1'b0;
  logic [CNT_W-1:0] convCount = '0;
  logic             holdReq = 1'b0;
  logic             eocN;
  logic [CNT_W-1:0] dispCount;
  logic             overRange, underRange, rangePulse;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  int expDisp = 0;
  bit loaded = 0;

  range_display_latch dut (
    .clk(clk), .rst(rst), .convDone(convDone), .convCount(convCount),
    .holdReq(holdReq), .eocN(eocN), .dispCount(dispCount),
    .overRange(overRange), .underRange(underRange), .rangePulse(rangePulse)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkDisplay(input string req);
    chk(int'(dispCount) == expDisp, {req, " dispCount"}, int'(dispCount), expDisp);
    chk(overRange == (loaded && expDisp > FS), {req, " R5 overRange"},
        int'(overRange), int'(loaded && expDisp > FS));
    chk(underRange == (loaded && expDisp <= LL), {req, " R6 underRange"},
        int'(underRange), int'(loaded && expDisp <= LL));
  endtask

  task automatic doConv(input int v, input bit hold, input bit busy, input int v2);
    int lowCnt = 0;
    int pulseCnt = 0;
    bit outR = (v > FS) || (v <= LL);
    if (hold) begin
      holdReq = 1'b1;
      repeat (3) @(negedge clk);
    end
    convDone  = 1'b1;
    convCount = CNT_W'(v);
    @(negedge clk);
    for (int i = 0; i < SLEN; i++) begin
      if (!eocN) lowCnt++;
      if (rangePulse) pulseCnt++;
      if (busy && i == 3) begin
        convDone  = 1'b1;
        convCount = CNT_W'(v2);
      end else begin
        convDone = 1'b0;
      end
      @(negedge clk);
    end
    convDone = 1'b0;
    chk(lowCnt == SLEN, hold ? "R4 R1 strobe length" : (busy ? "R8 R1 strobe length" : "R1 strobe length"),
        lowCnt, SLEN);
    chk(eocN == 1'b1, "R1 strobe released", int'(eocN), 1);
    chk(pulseCnt == (outR ? SLEN : 0), hold ? "R4 R7 rangePulse" : "R7 rangePulse",
        pulseCnt, outR ? SLEN : 0);
    chk(rangePulse == 1'b0, "R7 rangePulse after strobe", int'(rangePulse), 0);
    if (!hold) begin
      expDisp = v;
      loaded  = 1;
      checkDisplay(busy ? "R8" : "R2");
    end else begin
      checkDisplay("R3");
      holdReq = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(eocN == 1'b1, "R9 eocN reset", int'(eocN), 1);
    chk(rangePulse == 1'b0, "R9 rangePulse reset", int'(rangePulse), 0);
    checkDisplay("R9");
    // hold on the first conversion: display stays at reset values
    doConv(100, 1'b1, 1'b0, 0);
    // full sweep of the count range
    for (int v = 0; v < (1 << CNT_W); v++) begin
      doConv(v, (v % 7) == 3, 1'b0, 0);
    end
    // overlapping conversion-done pulses during a strobe
    doConv(381, 1'b0, 1'b1, 4000);
    doConv(4000, 1'b0, 1'b1, 380);
    doConv(3999, 1'b0, 1'b1, 0);
    // reset in the middle of operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expDisp = 0;
    loaded  = 0;
    @(negedge clk);
    chk(eocN == 1'b1, "R9 eocN second reset", int'(eocN), 1);
    checkDisplay("R9");
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule